// File: doc/BRIEF.md
# USB Bulk Endpoint Buffer Manager

This block owns the packet buffers and the per-endpoint status of the bulk and interrupt endpoints of a USB device. There are eight endpoint numbers in each direction, and each endpoint has a 64-byte buffer. A USB engine sits on one side. It presents tokens, pushes the bytes of received OUT packets, pulls the bytes of IN packets and reports completion. A local microcontroller sits on the other side and uses a byte-wide register bus. Through that bus it fills and drains buffers, loads byte counts, sets stall and enable bits, and clears service requests.

Each buffer is either owned by the USB side (busy) or by the CPU. The CPU hands a buffer to the USB side by writing its byte count. The buffer comes back when the packet completes, and at that moment the endpoint's service request bit is raised. While a buffer is busy, CPU writes to it and to its count are refused and an error pulse is given.

IN and OUT endpoints 2, 4 and 6 can each absorb the next higher endpoint number as a second buffer. The CPU and the USB side then alternate between the two buffers independently, each with its own pointer.

Top module: `epbuf_mgr`

## Requirements
- R1: After reset all buffers are CPU-owned and all counts read 0. No stall, pairing or request bit is set. Only endpoint 0 of each direction reads as valid. `epReq` is 0.
- R2: CPU address bit 10 = 0 selects buffer memory as {0, dir, ep[2:0], byte[5:0]}, where dir 1 = IN and 0 = OUT. A byte written to a CPU-owned buffer reads back on `cpuRdata` one cycle after the read cycle.
- R3: Register address is {1, dir, ep, 4'b0, sel}. With sel 0 (count), a write to a CPU-owned buffer stores min(wdata, 64) and makes the buffer busy (sel 1, bit 0). An IN token then returns ACK with `usbInLen` equal to that count. Each `usbRdEn` returns the next buffer byte one cycle later. `usbInAck` clears busy and sets the request bit.
- R4: For a busy OUT buffer, a token returns ACK. Each `usbWrEn` stores the next byte in order. `usbOutDone` clears busy, latches the number of bytes received as the count and sets the request bit.
- R5: `usbRespValid` pulses in the cycle after every token, with `usbResp` coded 0 none, 1 ACK, 2 NAK, 3 STALL. A valid, unstalled endpoint whose USB-side buffer is not busy answers NAK.
- R6: The sel 3 register holds bit 0 = endpoint valid and bit 1 = pair enable. A token to an endpoint that is not valid answers none. Endpoint 0 always reads valid, and writes to its valid bit have no effect.
- R7: sel 1 bit 1 is a stall bit that the CPU can write. A stalled valid endpoint answers STALL, and the following data and completion strobes change neither its buffer, its count nor its busy bit.
- R8: A CPU write to the buffer or the count of a busy buffer is ignored, and `cpuErr` pulses in the cycle after the write.
- R9: `epReq` bit dir*8+ep is the request bit and reads as sel 2 bit 0. Writing 1 to sel 2 bit 0 clears it. Writing 0 leaves it set.
- R10: The pair enable bit can be set only on endpoints 2, 4 and 6 of either direction. On every other endpoint it stays 0.
- R11: When pairing is enabled, the base endpoint's addresses refer to the CPU-side buffer of the pair. Tokens to the base are served from the USB-side buffer. Both pointers toggle on each hand-over. The pair reads busy only when both of its buffers are busy.
- R12: While pairing is enabled, tokens to the partner (next higher) endpoint answer none, and CPU writes to its buffer, count or stall bit are ignored without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuSel | input | 1 | CPU bus access strobe |
| cpuWe | input | 1 | CPU write (1) or read (0) |
| cpuAddr | input | 11 | CPU address (buffer or register space) |
| cpuWdata | input | 8 | CPU write data |
| cpuRdata | output | 8 | CPU read data, one cycle after the access |
| cpuErr | output | 1 | Pulse: refused write to a busy buffer |
| usbTokValid | input | 1 | Token strobe from the USB engine |
| usbTokDir | input | 1 | Token direction, 1 = IN |
| usbTokEp | input | 3 | Token endpoint number |
| usbRespValid | output | 1 | Handshake decision valid |
| usbResp | output | 2 | 0 none, 1 ACK, 2 NAK, 3 STALL |
| usbInLen | output | 7 | Byte count of the IN packet being served |
| usbWrEn | input | 1 | OUT data byte strobe |
| usbWrData | input | 8 | OUT data byte |
| usbOutDone | input | 1 | OUT packet received correctly |
| usbRdEn | input | 1 | IN data byte request |
| usbRdData | output | 8 | IN data byte, one cycle after the request |
| usbInAck | input | 1 | Host acknowledged the IN packet |
| epReq | output | 16 | Service request bits, index dir*8+ep |

## Verification
An ownership bit that is wrong appears at the very next token as a NAK in place of an ACK, or the reverse. It also appears at once as a busy flag in the status read, and as an error pulse, or a missing one, on the cycle after a CPU write. A ping-pong pointer that points at the wrong buffer gives the wrong `usbInLen` or the wrong first data byte one cycle after the token. A count that is latched wrongly is seen as soon as the CPU reads the count register. The bench drives random packet lengths and contents through both directions and through a paired endpoint. It compares every byte and every count against its own model, and it adds directed cases for stall, saturation, the endpoint-0 rules and the partner-endpoint rules.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;
  localparam int EP_PER_DIR = 8;
  localparam int BUF_BYTES  = 64;
  localparam int DATA_W     = 8;
  localparam int EP_W       = $clog2(EP_PER_DIR);
  localparam int IDX_W      = EP_W + 1;           // {dir, ep}
  localparam int NUM_BUF    = 2 * EP_PER_DIR;
  localparam int BYTE_W     = $clog2(BUF_BYTES);
  localparam int CNT_W      = BYTE_W + 1;
  localparam int ADDR_W     = 1 + IDX_W + BYTE_W;
  localparam int MEM_DEPTH  = NUM_BUF * BUF_BYTES;

  typedef enum logic [1:0] {
    RESP_NONE  = 2'd0,
    RESP_ACK   = 2'd1,
    RESP_NAK   = 2'd2,
    RESP_STALL = 2'd3
  } usbResp_e;

  typedef struct packed {
    logic              cpuWrEn;
    logic [IDX_W-1:0]  cpuBuf;
    logic [BYTE_W-1:0] cpuIdx;
    logic [DATA_W-1:0] cpuWrData;
    logic              usbWrEn;
    logic              usbRdEn;
    logic [IDX_W-1:0]  usbBuf;
    logic [BYTE_W-1:0] usbIdx;
    logic [DATA_W-1:0] usbWrData;
  } memStrobe_t;

  function automatic logic [NUM_BUF-1:0] pairableMask();
    logic [NUM_BUF-1:0] m;
    for (int l = 0; l < NUM_BUF; l++) begin
      int ep;
      ep = l % EP_PER_DIR;
      m[l] = (ep != 0) && (ep % 2 == 0) && (ep + 1 < EP_PER_DIR);
    end
    return m;
  endfunction

  function automatic logic [NUM_BUF-1:0] fixedValidMask();
    logic [NUM_BUF-1:0] m;
    for (int l = 0; l < NUM_BUF; l++) m[l] = (l % EP_PER_DIR) == 0;
    return m;
  endfunction
endpackage

// File: rtl/epbuf_data.sv
module epbuf_data
  import epbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strb,
  output logic [DATA_W-1:0] memCpuRdata,
  output logic [DATA_W-1:0] usbRdData
);
  logic [DATA_W-1:0] mem [MEM_DEPTH];

  logic [IDX_W+BYTE_W-1:0] cpuLoc, usbLoc;
  assign cpuLoc = {strb.cpuBuf, strb.cpuIdx};
  assign usbLoc = {strb.usbBuf, strb.usbIdx};

  always_ff @(posedge clk) begin
    if (strb.cpuWrEn) mem[cpuLoc] <= strb.cpuWrData;
    if (strb.usbWrEn) mem[usbLoc] <= strb.usbWrData;
    memCpuRdata <= mem[cpuLoc];
    if (strb.usbRdEn) usbRdData <= mem[usbLoc];
  end

  // the two write ports must never land in the same buffer (ownership gating)
  assert_no_port_clash_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.cpuWrEn && strb.usbWrEn && strb.cpuBuf == strb.usbBuf));
endmodule

// File: rtl/epbuf_ctrl.sv
module epbuf_ctrl
  import epbuf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuSel,
  input  logic               cpuWe,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [DATA_W-1:0]  cpuWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic               regSelQ,
  output logic               cpuErr,
  input  logic               usbTokValid,
  input  logic               usbTokDir,
  input  logic [EP_W-1:0]    usbTokEp,
  output logic               usbRespValid,
  output logic [1:0]         usbResp,
  output logic [CNT_W-1:0]   usbInLen,
  input  logic               usbWrEn,
  input  logic [DATA_W-1:0]  usbWrData,
  input  logic               usbOutDone,
  input  logic               usbRdEn,
  input  logic               usbInAck,
  output logic [NUM_BUF-1:0] epReq,
  output memStrobe_t         strb
);
  localparam logic [NUM_BUF-1:0] PAIRABLE    = pairableMask();
  localparam logic [NUM_BUF-1:0] FIXED_VALID = fixedValidMask();
  localparam logic [CNT_W-1:0]   CNT_MAX     = CNT_W'(BUF_BYTES);
  localparam logic [DATA_W-1:0]  WDATA_MAX   = DATA_W'(BUF_BYTES);

  // per-buffer / per-endpoint state
  logic [NUM_BUF-1:0] own;       // 1 = owned by USB side (busy)
  logic [NUM_BUF-1:0] stall;
  logic [NUM_BUF-1:0] valid;
  logic [NUM_BUF-1:0] req;
  logic [NUM_BUF-1:0] pairEn;
  logic [NUM_BUF-1:0] cpuPtr;
  logic [NUM_BUF-1:0] usbPtr;
  logic [CNT_W-1:0]   cnt [NUM_BUF];

  // current USB transaction
  logic               curActive;
  logic [IDX_W-1:0]   curL;
  logic [IDX_W-1:0]   curPhys;
  logic [CNT_W-1:0]   byteIdx;
  usbResp_e           respQ;

  logic [NUM_BUF-1:0] validEff;
  assign validEff = valid | FIXED_VALID;

  // ---------------- CPU decode ----------------
  logic              isReg, wrAcc, cpuPartner, cpuBusy;
  logic [IDX_W-1:0]  lCpu, cpuPhys;
  logic [BYTE_W-1:0] cpuIdx;
  logic [1:0]        regSel;
  logic              bufWr, cntWr, stallWr, reqClr, cfgWr, errNow;
  logic [CNT_W-1:0]  satCnt;
  logic [DATA_W-1:0] regNext;

  always_comb begin
    isReg      = cpuAddr[ADDR_W-1];
    lCpu       = cpuAddr[ADDR_W-2 -: IDX_W];
    cpuIdx     = cpuAddr[BYTE_W-1:0];
    regSel     = cpuAddr[1:0];
    wrAcc      = cpuSel && cpuWe;
    cpuPartner = lCpu[0] && pairEn[{lCpu[IDX_W-1:1], 1'b0}];
    cpuPhys    = pairEn[lCpu] ? {lCpu[IDX_W-1:1], cpuPtr[lCpu]} : lCpu;
    cpuBusy    = own[cpuPhys];
    bufWr   = wrAcc && !isReg && !cpuPartner && !cpuBusy;
    cntWr   = wrAcc && isReg && regSel == 2'd0 && !cpuPartner && !cpuBusy;
    errNow  = wrAcc && !cpuPartner && cpuBusy && (!isReg || regSel == 2'd0);
    stallWr = wrAcc && isReg && regSel == 2'd1 && !cpuPartner;
    reqClr  = wrAcc && isReg && regSel == 2'd2 && cpuWdata[0];
    cfgWr   = wrAcc && isReg && regSel == 2'd3;
    satCnt  = (cpuWdata > WDATA_MAX) ? CNT_MAX : cpuWdata[CNT_W-1:0];
    case (regSel)
      2'd0:    regNext = {{(DATA_W-CNT_W){1'b0}}, cnt[cpuPhys]};
      2'd1:    regNext = {{(DATA_W-2){1'b0}}, stall[lCpu],
                          pairEn[lCpu] ? (own[lCpu] && own[lCpu | IDX_W'(1)]) : own[lCpu]};
      2'd2:    regNext = {{(DATA_W-1){1'b0}}, req[lCpu]};
      default: regNext = {{(DATA_W-2){1'b0}}, pairEn[lCpu], validEff[lCpu]};
    endcase
  end

  // ---------------- USB decode ----------------
  logic [IDX_W-1:0] lTok, tokPhys;
  logic             tokPartner;
  usbResp_e         respNext;
  logic             outStep, inStep, outFin, inFin, finAny;

  always_comb begin
    lTok       = {usbTokDir, usbTokEp};
    tokPartner = lTok[0] && pairEn[{lTok[IDX_W-1:1], 1'b0}];
    tokPhys    = pairEn[lTok] ? {lTok[IDX_W-1:1], usbPtr[lTok]} : lTok;
    if (!validEff[lTok] || tokPartner) respNext = RESP_NONE;
    else if (stall[lTok])              respNext = RESP_STALL;
    else if (own[tokPhys])             respNext = RESP_ACK;
    else                               respNext = RESP_NAK;
    outStep = usbWrEn && curActive && !curL[IDX_W-1] && !usbTokValid;
    inStep  = usbRdEn && curActive && curL[IDX_W-1] && !usbTokValid;
    outFin  = usbOutDone && curActive && !curL[IDX_W-1] && !usbTokValid;
    inFin   = usbInAck && curActive && curL[IDX_W-1] && !usbTokValid;
    finAny  = outFin || inFin;
  end

  always_comb begin
    strb.cpuWrEn   = bufWr;
    strb.cpuBuf    = cpuPhys;
    strb.cpuIdx    = cpuIdx;
    strb.cpuWrData = cpuWdata;
    strb.usbWrEn   = outStep && (byteIdx < CNT_MAX);
    strb.usbRdEn   = inStep;
    strb.usbBuf    = curPhys;
    strb.usbIdx    = byteIdx[BYTE_W-1:0];
    strb.usbWrData = usbWrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      own <= '0; stall <= '0; valid <= '0; req <= '0;
      pairEn <= '0; cpuPtr <= '0; usbPtr <= '0;
      for (int i = 0; i < NUM_BUF; i++) cnt[i] <= '0;
      curActive <= 1'b0; curL <= '0; curPhys <= '0; byteIdx <= '0;
      respQ <= RESP_NONE; usbRespValid <= 1'b0; usbInLen <= '0;
      cpuErr <= 1'b0; regSelQ <= 1'b0; regRdata <= '0;
    end else begin
      usbRespValid <= usbTokValid;
      if (usbTokValid) begin
        respQ     <= respNext;
        curL      <= lTok;
        curPhys   <= tokPhys;
        curActive <= (respNext == RESP_ACK);
        byteIdx   <= '0;
        usbInLen  <= cnt[tokPhys];
      end else begin
        if ((outStep || inStep) && byteIdx < CNT_MAX) byteIdx <= byteIdx + 1'b1;
        if (finAny) begin
          own[curPhys]  <= 1'b0;
          usbPtr[curL]  <= usbPtr[curL] ^ pairEn[curL];
          curActive     <= 1'b0;
          if (outFin) cnt[curPhys] <= byteIdx;
        end
      end
      if (cntWr) begin
        cnt[cpuPhys]  <= satCnt;
        own[cpuPhys]  <= 1'b1;
        cpuPtr[lCpu]  <= cpuPtr[lCpu] ^ pairEn[lCpu];
      end
      if (stallWr) stall[lCpu] <= cpuWdata[1];
      if (cfgWr) begin
        valid[lCpu] <= cpuWdata[0];
        if (PAIRABLE[lCpu]) begin
          pairEn[lCpu] <= cpuWdata[1];
          cpuPtr[lCpu] <= 1'b0;
          usbPtr[lCpu] <= 1'b0;
        end
      end
      if (reqClr) req[lCpu] <= 1'b0;
      if (finAny) req[curL] <= 1'b1;       // a new request wins over a clear
      cpuErr   <= errNow;
      regSelQ  <= isReg;
      regRdata <= regNext;
    end
  end

  assign usbResp = respQ;
  assign epReq   = req;

  // a handshake decision follows every token
  assert_resp_follows_token_R5: assert property (@(posedge clk) disable iff (!rstN)
    usbTokValid |=> usbRespValid);

  // an error pulse only ever follows a CPU write
  assert_err_after_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    cpuErr |-> $past(cpuSel && cpuWe));

  // a completed OUT packet returns its buffer to the CPU
  assert_done_frees_R4: assert property (@(posedge clk) disable iff (!rstN)
    (usbOutDone && curActive && !curL[IDX_W-1] && !usbTokValid) |=> !own[$past(curPhys)]);

  for (genvar g = 0; g < NUM_BUF; g++) begin : gCntChk
    assert_count_max_R3: assert property (@(posedge clk) disable iff (!rstN)
      cnt[g] <= CNT_MAX);
  end
endmodule

// File: rtl/epbuf_mgr.sv
module epbuf_mgr
  import epbuf_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               cpuSel,
  input  logic               cpuWe,
  input  logic [ADDR_W-1:0]  cpuAddr,
  input  logic [DATA_W-1:0]  cpuWdata,
  output logic [DATA_W-1:0]  cpuRdata,
  output logic               cpuErr,
  input  logic               usbTokValid,
  input  logic               usbTokDir,
  input  logic [EP_W-1:0]    usbTokEp,
  output logic               usbRespValid,
  output logic [1:0]         usbResp,
  output logic [CNT_W-1:0]   usbInLen,
  input  logic               usbWrEn,
  input  logic [DATA_W-1:0]  usbWrData,
  input  logic               usbOutDone,
  input  logic               usbRdEn,
  output logic [DATA_W-1:0]  usbRdData,
  input  logic               usbInAck,
  output logic [NUM_BUF-1:0] epReq
);
  memStrobe_t        strb;
  logic [DATA_W-1:0] regRdata, memCpuRdata;
  logic              regSelQ;

  epbuf_ctrl uCtrl (
    .clk, .rstN, .cpuSel, .cpuWe, .cpuAddr, .cpuWdata,
    .regRdata, .regSelQ, .cpuErr,
    .usbTokValid, .usbTokDir, .usbTokEp, .usbRespValid, .usbResp, .usbInLen,
    .usbWrEn, .usbWrData, .usbOutDone, .usbRdEn, .usbInAck,
    .epReq, .strb
  );

  epbuf_data uData (
    .clk, .rstN, .strb, .memCpuRdata, .usbRdData
  );

  assign cpuRdata = regSelQ ? regRdata : memCpuRdata;
endmodule

// File: tb/tb_epbuf_mgr.sv
module tb_epbuf_mgr;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic cpuSel = 0, cpuWe = 0;
  logic [10:0] cpuAddr = '0;
  logic [7:0] cpuWdata = '0, cpuRdata, usbWrData = '0, usbRdData;
  logic cpuErr, usbTokValid = 0, usbTokDir = 0, usbRespValid;
  logic [2:0] usbTokEp = '0;
  logic [1:0] usbResp;
  logic [6:0] usbInLen;
  logic usbWrEn = 0, usbOutDone = 0, usbRdEn = 0, usbInAck = 0;
  logic [15:0] epReq;

  int checks = 0, fails = 0;
  logic [7:0] modelA [64];
  logic [7:0] modelB [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  epbuf_mgr dut (.*);

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] bufA(bit dir, int ep, int i);
    return {1'b0, dir, 3'(ep), 6'(i)};
  endfunction
  function automatic logic [10:0] regA(bit dir, int ep, int sel);
    return {1'b1, dir, 3'(ep), 4'b0, 2'(sel)};
  endfunction
  function automatic int satCnt(int w);
    return (w > 64) ? 64 : w;
  endfunction
  function automatic int expResp(bit v, bit s, bit armed);
    if (!v) return 0;
    if (s) return 3;
    return armed ? 1 : 2;
  endfunction

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic cpuWrite(logic [10:0] a, logic [7:0] d, output logic err);
    cpuSel = 1; cpuWe = 1; cpuAddr = a; cpuWdata = d; tick();
    cpuSel = 0; cpuWe = 0; err = cpuErr;
  endtask
  task automatic cpuRead(logic [10:0] a, output logic [7:0] d);
    cpuSel = 1; cpuWe = 0; cpuAddr = a; tick();
    cpuSel = 0; d = cpuRdata;
  endtask
  task automatic token(bit dir, int ep, output int resp, output int len, output bit rv);
    usbTokValid = 1; usbTokDir = dir; usbTokEp = 3'(ep); tick();
    usbTokValid = 0; rv = usbRespValid; resp = usbResp; len = usbInLen;
  endtask
  task automatic usbPush(logic [7:0] d);
    usbWrEn = 1; usbWrData = d; tick(); usbWrEn = 0;
  endtask
  task automatic usbPull(output logic [7:0] d);
    usbRdEn = 1; tick(); usbRdEn = 0; d = usbRdData;
  endtask
  task automatic pulseDone(); usbOutDone = 1; tick(); usbOutDone = 0; endtask
  task automatic pulseAck();  usbInAck = 1;  tick(); usbInAck = 0;  endtask

  // one unpaired IN packet on IN endpoint ep
  task automatic inFlow(int ep, int len);
    logic e; logic [7:0] d; int r, l; bit rv;
    for (int i = 0; i < len; i++) begin
      modelA[i] = 8'($urandom);
      cpuWrite(bufA(1, ep, i), modelA[i], e);
    end
    cpuRead(bufA(1, ep, len-1), d); chk("R2 buffer readback", d, modelA[len-1]);
    cpuWrite(regA(1, ep, 0), 8'(len), e);
    cpuRead(regA(1, ep, 1), d); chk("R3 busy after count write", d[0], 1);
    cpuWrite(bufA(1, ep, 0), ~modelA[0], e); chk("R8 err on busy buffer write", e, 1);
    cpuRead(bufA(1, ep, 0), d); chk("R8 busy buffer unchanged", d, modelA[0]);
    cpuWrite(regA(1, ep, 0), 8'd3, e); chk("R8 err on busy count write", e, 1);
    cpuRead(regA(1, ep, 0), d); chk("R8 busy count unchanged", d, len);
    token(1, ep, r, l, rv);
    chk("R5 resp valid", rv, 1); chk("R3 IN ack", r, expResp(1, 0, 1));
    chk("R3 IN length", l, len);
    for (int i = 0; i < len; i++) begin
      usbPull(d); chk("R3 IN byte", d, modelA[i]);
    end
    pulseAck();
    cpuRead(regA(1, ep, 1), d); chk("R3 busy cleared", d[0], 0);
    chk("R3 request set", epReq[8+ep], 1);
    cpuWrite(regA(1, ep, 2), 8'd0, e); chk("R9 write 0 keeps request", epReq[8+ep], 1);
    cpuWrite(regA(1, ep, 2), 8'd1, e); chk("R9 write 1 clears request", epReq[8+ep], 0);
  endtask

  // one unpaired OUT packet on OUT endpoint ep
  task automatic outFlow(int ep, int len);
    logic e; logic [7:0] d; int r, l; bit rv;
    cpuWrite(regA(0, ep, 0), 8'd0, e);
    cpuRead(regA(0, ep, 1), d); chk("R4 armed busy", d[0], 1);
    token(0, ep, r, l, rv); chk("R4 OUT ack", r, 1);
    for (int i = 0; i < len; i++) begin
      modelA[i] = 8'($urandom); usbPush(modelA[i]);
    end
    pulseDone();
    cpuRead(regA(0, ep, 0), d); chk("R4 latched count", d, len);
    cpuRead(regA(0, ep, 1), d); chk("R4 busy cleared", d[0], 0);
    chk("R4 request set", epReq[ep], 1);
    for (int i = 0; i < len; i++) begin
      cpuRead(bufA(0, ep, i), d); chk("R4 OUT byte", d, modelA[i]);
    end
    cpuWrite(regA(0, ep, 2), 8'd1, e); chk("R9 clear OUT request", epReq[ep], 0);
    token(0, ep, r, l, rv); chk("R5 NAK when not armed", r, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic e; logic [7:0] d; int r, l; bit rv; int lenA, lenB;
    int unsigned seed;
    seed = $urandom(32'd4821);
    repeat (3) tick();
    rstN = 1; tick();

    // R1 reset state
    chk("R1 epReq zero", epReq, 0);
    chk("R1 no resp", usbRespValid, 0);
    cpuRead(regA(1, 2, 0), d); chk("R1 count zero", d, 0);
    cpuRead(regA(0, 1, 1), d); chk("R1 cs zero", d, 0);
    cpuRead(regA(1, 5, 2), d); chk("R1 request zero", d, 0);
    cpuRead(regA(0, 0, 3), d); chk("R1 OUT0 valid", d, 1);
    cpuRead(regA(1, 0, 3), d); chk("R1 IN0 valid", d, 1);
    cpuRead(regA(1, 2, 3), d); chk("R1 IN2 cfg zero", d, 0);

    // R6 validity
    token(1, 1, r, l, rv); chk("R5 resp pulse", rv, 1);
    chk("R6 invalid endpoint none", r, expResp(0, 0, 0));
    token(0, 0, r, l, rv); chk("R6 ep0 valid NAK", r, 2);
    cpuWrite(regA(0, 0, 3), 8'd0, e);
    cpuRead(regA(0, 0, 3), d); chk("R6 ep0 valid fixed", d[0], 1);
    cpuWrite(regA(1, 1, 3), 8'd3, e);                 // valid + pair attempt
    cpuRead(regA(1, 1, 3), d); chk("R10 IN1 not pairable", d, 1);
    cpuWrite(regA(0, 1, 3), 8'd1, e);
    cpuWrite(regA(0, 7, 3), 8'd3, e);
    cpuRead(regA(0, 7, 3), d); chk("R10 OUT7 not pairable", d, 1);

    // R2 buffer edges
    cpuWrite(bufA(0, 5, 0), 8'hA5, e); cpuWrite(bufA(0, 5, 63), 8'h3C, e);
    cpuRead(bufA(0, 5, 0), d);  chk("R2 byte 0", d, 8'hA5);
    cpuRead(bufA(0, 5, 63), d); chk("R2 byte 63", d, 8'h3C);

    // random IN / OUT traffic
    for (int k = 0; k < 4; k++) begin
      inFlow(1, 1 + int'($urandom % 64));
      outFlow(1, 1 + int'($urandom % 64));
    end
    inFlow(1, 64);
    outFlow(1, 1);

    // R3 count saturation
    cpuWrite(regA(1, 1, 0), 8'd100, e);
    cpuRead(regA(1, 1, 0), d); chk("R3 count saturates", d, satCnt(100));
    token(1, 1, r, l, rv); chk("R3 saturated length", l, 64);
    pulseAck();
    cpuWrite(regA(1, 1, 2), 8'd1, e);

    // R7 stall on OUT1 (buffer byte 0 holds modelA[0] from last OUT)
    cpuWrite(regA(0, 1, 1), 8'd2, e);
    cpuWrite(regA(0, 1, 0), 8'd0, e);
    token(0, 1, r, l, rv); chk("R7 stall response", r, expResp(1, 1, 1));
    usbPush(~modelA[0]); usbPush(8'h11); pulseDone();
    cpuRead(regA(0, 1, 1), d); chk("R7 stalled stays busy", d, 3);
    chk("R7 no request", epReq[1], 0);
    cpuWrite(regA(0, 1, 1), 8'd0, e);
    token(0, 1, r, l, rv); chk("R7 unstalled ack", r, 1);
    pulseDone();
    cpuRead(bufA(0, 1, 0), d); chk("R7 buffer untouched", d, modelA[0]);
    cpuRead(regA(0, 1, 0), d); chk("R7 zero-length count", d, 0);
    cpuWrite(regA(0, 1, 2), 8'd1, e);

    // R11 ping-pong on IN2 (partner IN3)
    cpuWrite(regA(1, 3, 3), 8'd1, e);
    cpuWrite(regA(1, 2, 3), 8'd3, e);
    cpuRead(regA(1, 2, 3), d); chk("R10 IN2 pairable", d, 3);
    lenA = 1 + int'($urandom % 16); lenB = 1 + int'($urandom % 16);
    for (int i = 0; i < lenA; i++) begin
      modelA[i] = 8'($urandom); cpuWrite(bufA(1, 2, i), modelA[i], e);
    end
    cpuWrite(regA(1, 2, 0), 8'(lenA), e);
    cpuRead(regA(1, 2, 1), d); chk("R11 one armed not busy", d[0], 0);
    for (int i = 0; i < lenB; i++) begin
      modelB[i] = 8'($urandom); cpuWrite(bufA(1, 2, i), modelB[i], e);
      chk("R11 second buffer writable", e, 0);
    end
    cpuWrite(regA(1, 2, 0), 8'(lenB), e);
    cpuRead(regA(1, 2, 1), d); chk("R11 both armed busy", d[0], 1);
    token(1, 2, r, l, rv); chk("R11 first ack", r, 1); chk("R11 first length", l, lenA);
    for (int i = 0; i < lenA; i++) begin usbPull(d); chk("R11 first data", d, modelA[i]); end
    pulseAck();
    cpuRead(regA(1, 2, 1), d); chk("R11 busy after one done", d[0], 0);
    chk("R11 request set", epReq[10], 1);
    token(1, 2, r, l, rv); chk("R11 second length", l, lenB);
    for (int i = 0; i < lenB; i++) begin usbPull(d); chk("R11 second data", d, modelB[i]); end
    pulseAck();
    token(1, 2, r, l, rv); chk("R11 drained NAK", r, 2);

    // R12 partner endpoint while paired
    token(1, 3, r, l, rv); chk("R12 partner token none", r, 0);
    cpuWrite(regA(1, 3, 0), 8'd5, e); chk("R12 partner write no error", e, 0);
    cpuRead(regA(1, 3, 0), d); chk("R12 partner count unchanged", d, lenB);
    cpuWrite(regA(1, 3, 1), 8'd2, e);
    cpuRead(regA(1, 3, 1), d); chk("R12 partner stall ignored", d[1], 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule